// File: doc/BRIEF.md
# Auto-Reload Down-Counter Interval Timer

This block is an interval timer with a 16-bit down-counter that reloads itself from a programmable latch. It counts in one of two ways. In free-running mode it counts once per system clock. In cascaded mode it counts once per pulse on an enable input, which is typically the underflow pulse of a second instance. A host reaches it through a small synchronous byte-wide register port. The host writes the latch one byte at a time, reads the live count one byte at a time, starts and stops counting, picks the count source, and polls an underflow flag that clears when it is read.

The reload is deliberately lazy. A counter that has reached zero reloads only when the next count arrives. Count arrivals pass through one pipeline stage, so the timer knows a cycle ahead whether another count is on its way. As a result, a zero is never visible in free-running mode. In cascaded mode a zero can be held for several cycles between sparse enable pulses. Each reload raises a one-cycle underflow pulse and sets the flag.

Top module: `ivl_timer`

## Requirements
- R1: After reset the count reads 0xFFFF, the latch holds 0xFFFF, the control register reads 0, the flag register reads 0 and the underflow pulse is low.
- R2: Register map on the 2-bit address:
  - Address 0: a write sets the latch low byte, and a read returns the count low byte.
  - Address 1: a write sets the latch high byte, and a read returns the count high byte.
  - Address 2: the control register, read back as written. Bit 0 = run. Bit 1 = cascaded mode.
  - Address 3: the flag register. Bit 0 = underflow.
  - Read data is combinational from the address. The 16-bit count is high byte << 8 | low byte.
- R3: A high-byte latch write while stopped also loads the count with {written byte, latch low byte} at the same edge. While running, latch writes leave the count alone and take effect at the next reload.
- R4: In free-running mode a count that would step from 1 to 0, with a further count already pending, reloads directly from the latch. With latch 2 and a stopped-loaded count of 2, the count reads 2,2,1,2,1,2,1,… starting at the edge of the run write. Zero is never read.
- R5: In cascaded mode each enable pulse is counted one cycle after it arrives. A count held at zero reloads in the cycle its releasing pulse is seen, and that pulse is then consumed. With latch 2 and a pulse every third cycle, the count holds 0 for two cycles between 1 and 2 (…,2,2,2,1,1,1,0,0,2,…).
- R6: Each reload drives the underflow pulse high for the cycle in which the count first shows the reloaded latch value, and sets flag bit 0 at the same edge.
- R7: A read of address 3 with the read strobe set returns the flag and clears it at that edge, unless a reload happens at the same edge, in which case the flag stays set.
- R8: With run cleared the count holds its value and enable pulses are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (read side effects) |
| regAddr | input | 2 | Register address |
| regWrData | input | 8 | Write data byte |
| regRdData | output | 8 | Read data byte, combinational from address |
| cascadeTick | input | 1 | Count enable pulse for cascaded mode |
| underflowPulse | output | 1 | One-cycle pulse on each reload |

## Verification
The bench tracks the count cycle by cycle in both modes.
- In free-running mode, a design that reloads eagerly would show a zero.
- In cascaded mode, one that ignores the one-cycle lookahead would hold zero for the wrong number of cycles.
- One that fails to consume the releasing pulse would step straight from the latch value to one less.

It also lines a flag read up with a reload edge, where a clear-wins design would lose the underflow. Finally, it writes the latch while running, where a design that loads the count on every high-byte write would jump early.

// File: rtl/ivl_timer_pkg.sv
package ivl_timer_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_CNT_LO = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CNT_HI = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_FLAG   = 2'd3;

  typedef struct packed {
    logic latchLoWr;
    logic latchHiWr;
    logic forceLoad;
    logic reload;
    logic decrement;
  } tmrStrobe_t;
endpackage

// File: rtl/ivl_timer_ctrl.sv
module ivl_timer_ctrl
  import ivl_timer_pkg::*;
#(
  parameter int BW = 8,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic [AW-1:0] addr,
  input  logic [BW-1:0] wrData,
  input  logic          cascadeTick,
  input  logic          cntIsZero,
  input  logic          cntIsOne,
  output tmrStrobe_t    strb,
  output logic          runQ,
  output logic          cascadeQ,
  output logic          flagQ,
  output logic          underflowQ
);
  logic pend, actQ, actEff, absorb, skipZero, flagRead;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ     <= 1'b0;
      cascadeQ <= 1'b0;
    end else if (wrEn && addr == ADDR_CTRL) begin
      runQ     <= wrData[0];
      cascadeQ <= wrData[1];
    end
  end

  // a count is pending this cycle; it is applied one cycle later
  assign pend     = runQ && (cascadeQ ? cascadeTick : 1'b1);
  assign actEff   = actQ && runQ;
  assign absorb   = cntIsZero && pend;
  assign skipZero = cntIsOne && actEff && pend;
  assign flagRead = rdEn && addr == ADDR_FLAG;

  always_comb begin
    strb           = '0;
    strb.latchLoWr = wrEn && addr == ADDR_CNT_LO;
    strb.latchHiWr = wrEn && addr == ADDR_CNT_HI;
    strb.forceLoad = wrEn && addr == ADDR_CNT_HI && !runQ;
    strb.reload    = absorb || skipZero;
    strb.decrement = actEff && !cntIsZero && !skipZero;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actQ       <= 1'b0;
      underflowQ <= 1'b0;
      flagQ      <= 1'b0;
    end else begin
      actQ       <= pend && !absorb;
      underflowQ <= strb.reload;
      if (strb.reload) flagQ <= 1'b1;
      else if (flagRead) flagQ <= 1'b0;
    end
  end

  // R6
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.reload |=> flagQ);
  // R7
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagRead && !strb.reload |=> !flagQ);
endmodule

// File: rtl/ivl_timer_dp.sv
module ivl_timer_dp
  import ivl_timer_pkg::*;
#(
  parameter int BW = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  tmrStrobe_t      strb,
  input  logic [BW-1:0]   wrData,
  input  logic            runQ,
  input  logic            cascadeQ,
  output logic [2*BW-1:0] cntQ,
  output logic [2*BW-1:0] latchQ,
  output logic            cntIsZero,
  output logic            cntIsOne
);
  localparam int CW = 2 * BW;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latchQ <= '1;
    end else begin
      if (strb.latchLoWr) latchQ[BW-1:0]  <= wrData;
      if (strb.latchHiWr) latchQ[CW-1:BW] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '1;
    end else if (strb.forceLoad) begin
      cntQ <= {wrData, latchQ[BW-1:0]};
    end else if (strb.reload) begin
      cntQ <= latchQ;
    end else if (strb.decrement) begin
      cntQ <= cntQ - 1'b1;
    end
  end

  assign cntIsZero = (cntQ == '0);
  assign cntIsOne  = (cntQ == CW'(1));

  // R8
  hold_stopped_chk: assert property (@(posedge clk) disable iff (!rstN)
    !runQ && !strb.forceLoad |=> cntQ == $past(cntQ));
  // R4
  no_zero_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    runQ && !cascadeQ && $past(runQ) && !$past(cascadeQ)
      && latchQ != '0 && $past(latchQ) != '0 |-> cntQ != '0);
endmodule

// File: rtl/ivl_timer.sv
module ivl_timer
  import ivl_timer_pkg::*;
#(
  parameter int BYTE_WIDTH = ivl_timer_pkg::BYTE_W,
  parameter int ADDR_WIDTH = ivl_timer_pkg::ADDR_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic                  regRdEn,
  input  logic [ADDR_WIDTH-1:0] regAddr,
  input  logic [BYTE_WIDTH-1:0] regWrData,
  output logic [BYTE_WIDTH-1:0] regRdData,
  input  logic                  cascadeTick,
  output logic                  underflowPulse
);
  localparam int CW = 2 * BYTE_WIDTH;

  tmrStrobe_t    strb;
  logic          runQ, cascadeQ, flagQ, cntIsZero, cntIsOne;
  logic [CW-1:0] cntQ, latchQ;

  ivl_timer_ctrl #(.BW(BYTE_WIDTH), .AW(ADDR_WIDTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(regWrEn), .rdEn(regRdEn), .addr(regAddr),
    .wrData(regWrData), .cascadeTick(cascadeTick), .cntIsZero(cntIsZero),
    .cntIsOne(cntIsOne), .strb(strb), .runQ(runQ), .cascadeQ(cascadeQ),
    .flagQ(flagQ), .underflowQ(underflowPulse)
  );

  ivl_timer_dp #(.BW(BYTE_WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(regWrData), .runQ(runQ),
    .cascadeQ(cascadeQ), .cntQ(cntQ), .latchQ(latchQ),
    .cntIsZero(cntIsZero), .cntIsOne(cntIsOne)
  );

  always_comb begin
    case (regAddr)
      ADDR_CNT_LO: regRdData = cntQ[BYTE_WIDTH-1:0];
      ADDR_CNT_HI: regRdData = cntQ[CW-1:BYTE_WIDTH];
      ADDR_CTRL:   regRdData = {{(BYTE_WIDTH-2){1'b0}}, cascadeQ, runQ};
      default:     regRdData = {{(BYTE_WIDTH-1){1'b0}}, flagQ};
    endcase
  end

  // R6
  pulse_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    underflowPulse |-> cntQ == $past(latchQ));
endmodule

// File: tb/ivl_timer_tb.sv
module ivl_timer_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0, regRdEn = 1'b0, cascadeTick = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWrData = 8'd0;
  logic [7:0] regRdData;
  logic       underflowPulse;
  int nChecks = 0, nFails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  ivl_timer u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .cascadeTick(cascadeTick), .underflowPulse(underflowPulse)
  );

  // {tick driven, expected pulse, expected count}; cascaded mode, latch 2
  localparam logic [17:0] CASC_VEC [18] = '{
    {1'b1, 1'b0, 16'd2}, {1'b0, 1'b0, 16'd2}, {1'b0, 1'b0, 16'd1},
    {1'b1, 1'b0, 16'd1}, {1'b0, 1'b0, 16'd1}, {1'b0, 1'b0, 16'd0},
    {1'b1, 1'b0, 16'd0}, {1'b0, 1'b1, 16'd2}, {1'b0, 1'b0, 16'd2},
    {1'b1, 1'b0, 16'd2}, {1'b0, 1'b0, 16'd2}, {1'b0, 1'b0, 16'd1},
    {1'b1, 1'b0, 16'd1}, {1'b0, 1'b0, 16'd1}, {1'b0, 1'b0, 16'd0},
    {1'b1, 1'b0, 16'd0}, {1'b0, 1'b1, 16'd2}, {1'b0, 1'b0, 16'd2}
  };
  localparam logic [15:0] FREE_EXP [8] = '{16'd2, 16'd2, 16'd1, 16'd2,
                                           16'd1, 16'd2, 16'd1, 16'd2};

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    step();
    regWrEn = 1'b0;
  endtask

  task automatic readCnt(output logic [15:0] v);
    regAddr = 2'd0; #1; v[7:0] = regRdData;
    regAddr = 2'd1; #1; v[15:8] = regRdData;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [7:0] v);
    regAddr = a; #1; v = regRdData;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [15:0] c, held;
    logic [7:0]  r;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    readCnt(c);                    chk("R1 count", c, 16'hFFFF);
    readReg(2'd2, r);              chk("R1 ctrl", {8'd0, r}, 16'd0);
    readReg(2'd3, r);              chk("R1 flag", {8'd0, r}, 16'd0);
    chk("R1 pulse", {15'd0, underflowPulse}, 16'd0);

    // R3 stopped high-byte write loads count
    wrReg(2'd0, 8'd2);
    readCnt(c);                    chk("R3 lo write alone", c, 16'hFFFF);
    wrReg(2'd1, 8'd0);
    readCnt(c);                    chk("R3 stopped load", c, 16'd2);

    // R4 free-running sequence, R6 pulses
    wrReg(2'd2, 8'h01);
    readReg(2'd2, r);              chk("R2 ctrl readback", {8'd0, r}, 16'h0001);
    for (int k = 0; k < 8; k++) begin
      readCnt(c);                  chk("R4 free count", c, FREE_EXP[k]);
      chk("R6 free pulse", {15'd0, underflowPulse},
          {15'd0, (k >= 3) && (k % 2 == 1)});
      step();
    end

    // R8 stop holds count
    wrReg(2'd2, 8'h00);
    readCnt(held);
    cascadeTick = 1'b1;
    repeat (3) step();
    cascadeTick = 1'b0;
    readCnt(c);                    chk("R8 stopped hold", c, held);

    // R7 read clears flag
    regRdEn = 1'b1;
    readReg(2'd3, r);              chk("R7 flag set", {8'd0, r}, 16'd1);
    step();
    readReg(2'd3, r);              chk("R7 flag cleared", {8'd0, r}, 16'd0);
    regRdEn = 1'b0;

    // R3 running latch write affects next reload only
    wrReg(2'd0, 8'd2);
    wrReg(2'd1, 8'd0);
    wrReg(2'd2, 8'h01);            // after E0
    wrReg(2'd0, 8'd5);             // E1
    wrReg(2'd1, 8'd0);             // E2
    readCnt(c);                    chk("R3 running no load", c, 16'd1);
    step();
    readCnt(c);                    chk("R3 new latch reload", c, 16'd5);
    step();
    readCnt(c);                    chk("R3 count after reload", c, 16'd4);

    // R7 read coinciding with reload keeps flag
    wrReg(2'd2, 8'h00);
    wrReg(2'd0, 8'd2);
    wrReg(2'd1, 8'd0);
    wrReg(2'd2, 8'h01);            // after E0
    repeat (3) step();             // after E3, reload done
    regRdEn = 1'b1; regAddr = 2'd3;
    step();                        // E4 clears
    readReg(2'd3, r);              chk("R7 clear before reload", {8'd0, r}, 16'd0);
    step();                        // E5 reload and read together
    readReg(2'd3, r);              chk("R7 reload wins", {8'd0, r}, 16'd1);
    step();                        // E6 read alone
    readReg(2'd3, r);              chk("R7 clear after", {8'd0, r}, 16'd0);
    regRdEn = 1'b0;

    // R5 cascaded sequence from table
    wrReg(2'd2, 8'h00);
    wrReg(2'd0, 8'd2);
    wrReg(2'd1, 8'd0);
    wrReg(2'd2, 8'h03);            // after E0
    readReg(2'd2, r);              chk("R2 cascade readback", {8'd0, r}, 16'h0003);
    for (int i = 0; i < 18; i++) begin
      readCnt(c);                  chk("R5 cascade count", c, CASC_VEC[i][15:0]);
      chk("R6 cascade pulse", {15'd0, underflowPulse}, {15'd0, CASC_VEC[i][16]});
      cascadeTick = CASC_VEC[i][17];
      step();
      cascadeTick = 1'b0;
    end

    summary();
  end
endmodule